// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, a divided pixel clock with a matching one-cycle pixel enable, the coordinates of the pixel on screen, and a frame interrupt pulse. The pixel fetch path uses the pixel enable together with the coordinates to know when to present each pixel.

Software programs the timing through a small write-only register port. Each porch, pulse width and active size is held as its count minus one. The pixel rate is the source clock divided by the divider field plus one. Each output has its own inversion bit, and a 2-bit selector picks the line on which the frame interrupt fires. Output is gated by three things: an enable input, an immediate enable bit, and a frame-synchronised enable bit. Setting the frame-synchronised bit starts output at once. Clearing it lets the frame in progress finish.

Top module: `lcd_sync_gen`

## Requirements
- R1: Each line is ordered as sync pulse, back porch, active pixels, front porch. Their lengths in pixels are the three fields of register 1 plus one: sync in bits 7:0, back porch in bits 15:8, front porch in bits 23:16. The active width is bits 10:0 of register 3 plus one. The horizontal sync is asserted (before inversion) only during the sync pixels.
- R2: Frames follow the same ordering counted in lines. The lengths are the fields of register 2, in the same bit positions, plus one. The active height is bits 26:16 of register 3 plus one. The vertical sync is asserted (before inversion) for every pixel of the sync lines.
- R3: Data enable is asserted (before inversion) exactly on pixels that lie in both the active columns and the active lines. On those pixels, xPos and yPos count from 0 at the first active pixel and line. Elsewhere they read 0.
- R4: pclkEn pulses for one source cycle every (divider+1) source cycles, where the divider is bits 15:8 of register 0. All other outputs change only in the cycle where pclkEn is high, and describe that pixel.
- R5: Bits 4, 5, 6 and 7 of register 0 invert vsyncOut, hsyncOut, vdenOut and pclkOut respectively. When the block is idle, each of these outputs rests at its inversion bit.
- R6: Bits 3:2 of register 0 place the frameIrq pulse on the first pixel of a chosen line: 0 gives no pulse, 1 the first front-porch line, 2 line 0 (the first sync line), 3 the first active line. The pulse coincides with pclkEn.
- R7: While the enable input or the immediate enable bit (register 0 bit 0) is low, the block is idle. Within one source cycle the outputs go to their inactive levels, pclkEn and frameIrq go low, and the counters return to zero, so output resumes at pixel (0,0). Reset also leaves every output at 0.
- R8: Setting the frame-synchronised enable (register 0 bit 1) while idle starts output. Clearing it while running stops output only after the last pixel of the current frame, so that frame is delivered in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 horizontal, 2 vertical, 3 active size |
| wrData | input | 32 | Register write data |
| hsyncOut | output | 1 | Horizontal sync after inversion |
| vsyncOut | output | 1 | Vertical sync after inversion |
| vdenOut | output | 1 | Data enable after inversion |
| pclkOut | output | 1 | Divided pixel clock after inversion |
| pclkEn | output | 1 | One-cycle pixel enable |
| xPos | output | 11 | Active-area column |
| yPos | output | 11 | Active-area row |
| frameIrq | output | 1 | Frame interrupt pulse |

## Verification
The hardest case to reach is a clear of the frame-synchronised enable that lands in the middle of a frame other than the first. The pulse must then stop exactly at that frame's last pixel, not at once and not one frame later. The stimulus queues the exact pixels of two frames and watches how many the monitor has consumed. It clears the bit only after the second frame has started. Any pixel that arrives after the queue runs dry is reported as a failure. A second hard case is a restart after the enable input drops mid-line. After that drop, the first queued pixel must again be (0,0) with the sync timing of line 0.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic tick;
  } strobe_t;

  // bit order of the inversion mask
  localparam int INV_VS  = 0;
  localparam int INV_HS  = 1;
  localparam int INV_DE  = 2;
  localparam int INV_CLK = 3;

  typedef enum logic [1:0] {
    IRQ_OFF    = 2'd0,
    IRQ_FRONT  = 2'd1,
    IRQ_SYNC   = 2'd2,
    IRQ_ACTIVE = 2'd3
  } irq_sel_e;

endpackage

// File: rtl/lcd_sync_axis.sv
// Region boundaries of one timing axis from minus-one fields.
module lcd_sync_axis #(
  parameter int PW = 8,
  parameter int SW = 11,
  parameter int CW = 13
) (
  input  logic [PW-1:0] syncM1,
  input  logic [PW-1:0] backM1,
  input  logic [PW-1:0] frontM1,
  input  logic [SW-1:0] actM1,
  output logic [CW-1:0] syncEnd,
  output logic [CW-1:0] actStart,
  output logic [CW-1:0] frontStart,
  output logic [CW-1:0] total
);
  logic [CW-1:0] syncLen, backLen, actLen, frontLen;

  always_comb begin
    syncLen    = CW'(syncM1) + CW'(1);
    backLen    = CW'(backM1) + CW'(1);
    actLen     = CW'(actM1) + CW'(1);
    frontLen   = CW'(frontM1) + CW'(1);
    syncEnd    = syncLen;
    actStart   = syncLen + backLen;
    frontStart = actStart + actLen;
    total      = frontStart + frontLen;
  end
endmodule

// File: rtl/lcd_sync_ctrl.sv
// Register file, pixel clock divider and frame-synchronised enable.
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
#(
  parameter int PW     = 8,
  parameter int HW     = 11,
  parameter int VW     = 11,
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameEnd,
  output strobe_t           strb,
  output logic [PW-1:0]     hSyncM1,
  output logic [PW-1:0]     hBackM1,
  output logic [PW-1:0]     hFrontM1,
  output logic [PW-1:0]     vSyncM1,
  output logic [PW-1:0]     vBackM1,
  output logic [PW-1:0]     vFrontM1,
  output logic [HW-1:0]     hActM1,
  output logic [VW-1:0]     vActM1,
  output logic [1:0]        irqSel,
  output logic [3:0]        invMask,
  output logic              pclkOut
);
  localparam logic [AW-1:0] ADDR_CTL  = AW'(0);
  localparam logic [AW-1:0] ADDR_HOR  = AW'(1);
  localparam logic [AW-1:0] ADDR_VER  = AW'(2);
  localparam logic [AW-1:0] ADDR_SIZE = AW'(3);
  localparam int CTL_IMM    = 0;
  localparam int CTL_FRM    = 1;
  localparam int CTL_IRQ_LO = 2;
  localparam int CTL_INV_LO = 4;
  localparam int CTL_DIV_LO = 8;
  localparam int SIZE_V_LO  = 16;

  logic          immEn, frmReq, frmEn;
  logic [DW-1:0] divVal, divCnt, divHalf;
  logic          run, tick;
  logic          unusedBits;

  assign unusedBits = ^wrData;

  assign run     = enable & immEn & frmEn;
  assign tick    = run && (divCnt == divVal);
  assign divHalf = divVal >> 1;
  assign strb.run  = run;
  assign strb.tick = tick;

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      immEn    <= 1'b0;
      frmReq   <= 1'b0;
      irqSel   <= '0;
      invMask  <= '0;
      divVal   <= '0;
      hSyncM1  <= '0;
      hBackM1  <= '0;
      hFrontM1 <= '0;
      vSyncM1  <= '0;
      vBackM1  <= '0;
      vFrontM1 <= '0;
      hActM1   <= '0;
      vActM1   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTL: begin
          immEn   <= wrData[CTL_IMM];
          frmReq  <= wrData[CTL_FRM];
          irqSel  <= wrData[CTL_IRQ_LO +: 2];
          invMask <= wrData[CTL_INV_LO +: 4];
          divVal  <= wrData[CTL_DIV_LO +: DW];
        end
        ADDR_HOR: begin
          hSyncM1  <= wrData[0 +: PW];
          hBackM1  <= wrData[PW +: PW];
          hFrontM1 <= wrData[2*PW +: PW];
        end
        ADDR_VER: begin
          vSyncM1  <= wrData[0 +: PW];
          vBackM1  <= wrData[PW +: PW];
          vFrontM1 <= wrData[2*PW +: PW];
        end
        ADDR_SIZE: begin
          hActM1 <= wrData[0 +: HW];
          vActM1 <= wrData[SIZE_V_LO +: VW];
        end
        default: ;
      endcase
    end
  end

  // frame-synchronised enable: loads at once while idle, else at frame end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmEn <= 1'b0;
    end else if (!run || (tick && frameEnd)) begin
      frmEn <= frmReq;
    end
  end

  // pixel clock divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      pclkOut <= 1'b0;
    end else begin
      if (!run || divCnt == divVal) divCnt <= '0;
      else divCnt <= divCnt + DW'(1);
      pclkOut <= (run && divCnt <= divHalf) ^ invMask[INV_CLK];
    end
  end

  // R8: a running frame-synchronised enable drops only on the last pixel
  assert_stop_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!frmEn && $past(frmEn) && $past(run)) |-> $past(tick && frameEnd))
    else $error("frame enable dropped mid-frame");

  // R4: with a divider above zero, no two pixel strobes are adjacent
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divVal != '0) |=> (!tick || divVal == '0))
    else $error("pixel strobes too close");

endmodule

// File: rtl/lcd_sync_dp.sv
// Raster counters, region decode and registered outputs.
module lcd_sync_dp
  import lcd_sync_pkg::*;
#(
  parameter int PW = 8,
  parameter int HW = 11,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [PW-1:0] hSyncM1,
  input  logic [PW-1:0] hBackM1,
  input  logic [PW-1:0] hFrontM1,
  input  logic [PW-1:0] vSyncM1,
  input  logic [PW-1:0] vBackM1,
  input  logic [PW-1:0] vFrontM1,
  input  logic [HW-1:0] hActM1,
  input  logic [VW-1:0] vActM1,
  input  logic [1:0]    irqSel,
  input  logic [3:0]    invMask,
  output logic          frameEnd,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          vdenOut,
  output logic          pclkEn,
  output logic [HW-1:0] xPos,
  output logic [VW-1:0] yPos,
  output logic          frameIrq
);
  localparam int HCW = ((HW > PW) ? HW : PW) + 2;
  localparam int VCW = ((VW > PW) ? VW : PW) + 2;

  logic [HCW-1:0] hCnt, hSyncEnd, hActStart, hFrontStart, hTotal;
  logic [VCW-1:0] vCnt, vSyncEnd, vActStart, vFrontStart, vTotal;
  logic hLast, vLast, hSyncC, vSyncC, hActC, vActC, deC, irqC;

  lcd_sync_axis #(.PW(PW), .SW(HW), .CW(HCW)) uHorz (
    .syncM1(hSyncM1), .backM1(hBackM1), .frontM1(hFrontM1), .actM1(hActM1),
    .syncEnd(hSyncEnd), .actStart(hActStart), .frontStart(hFrontStart),
    .total(hTotal));

  lcd_sync_axis #(.PW(PW), .SW(VW), .CW(VCW)) uVert (
    .syncM1(vSyncM1), .backM1(vBackM1), .frontM1(vFrontM1), .actM1(vActM1),
    .syncEnd(vSyncEnd), .actStart(vActStart), .frontStart(vFrontStart),
    .total(vTotal));

  always_comb begin
    hLast    = (hCnt == hTotal - HCW'(1));
    vLast    = (vCnt == vTotal - VCW'(1));
    frameEnd = hLast && vLast;
    hSyncC   = hCnt < hSyncEnd;
    vSyncC   = vCnt < vSyncEnd;
    hActC    = (hCnt >= hActStart) && (hCnt < hFrontStart);
    vActC    = (vCnt >= vActStart) && (vCnt < vFrontStart);
    deC      = hActC && vActC;
    case (irq_sel_e'(irqSel))
      IRQ_FRONT:  irqC = (hCnt == '0) && (vCnt == vFrontStart);
      IRQ_SYNC:   irqC = (hCnt == '0) && (vCnt == '0);
      IRQ_ACTIVE: irqC = (hCnt == '0) && (vCnt == vActStart);
      default:    irqC = 1'b0;
    endcase
  end

  // raster counters advance on pixel strobes only
  always_ff @(posedge clk) begin
    if (!rstN || !strb.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.tick) begin
      if (hLast) begin
        hCnt <= '0;
        vCnt <= vLast ? '0 : vCnt + VCW'(1);
      end else begin
        hCnt <= hCnt + HCW'(1);
      end
    end
  end

  // registered outputs describe the pixel of the current strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      vdenOut  <= 1'b0;
      pclkEn   <= 1'b0;
      frameIrq <= 1'b0;
      xPos     <= '0;
      yPos     <= '0;
    end else if (!strb.run) begin
      hsyncOut <= invMask[INV_HS];
      vsyncOut <= invMask[INV_VS];
      vdenOut  <= invMask[INV_DE];
      pclkEn   <= 1'b0;
      frameIrq <= 1'b0;
      xPos     <= '0;
      yPos     <= '0;
    end else begin
      pclkEn   <= strb.tick;
      frameIrq <= strb.tick && irqC;
      if (strb.tick) begin
        hsyncOut <= hSyncC ^ invMask[INV_HS];
        vsyncOut <= vSyncC ^ invMask[INV_VS];
        vdenOut  <= deC ^ invMask[INV_DE];
        xPos     <= deC ? HW'(hCnt - hActStart) : '0;
        yPos     <= deC ? VW'(vCnt - vActStart) : '0;
      end
    end
  end

  // R6: the frame interrupt only rides on a pixel strobe
  assert_irq_on_pixel_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> pclkEn)
    else $error("frame interrupt without pixel strobe");

  // R7: a cycle without run leaves the outputs idle on the next
  assert_idle_after_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (!pclkEn && !frameIrq &&
                   vdenOut == $past(invMask[INV_DE]) &&
                   hsyncOut == $past(invMask[INV_HS])))
    else $error("outputs not idle after stop");

  // R3: an active pixel never overlaps a sync pulse
  assert_de_outside_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((vdenOut ^ invMask[INV_DE]) && $stable(invMask)) |->
      (!(hsyncOut ^ invMask[INV_HS]) && !(vsyncOut ^ invMask[INV_VS])))
    else $error("data enable during sync");

endmodule

// File: rtl/lcd_sync_gen.sv
// Top: LCD sync timing generator.
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int PW     = 8,
  parameter int HW     = 11,
  parameter int VW     = 11,
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              vdenOut,
  output logic              pclkOut,
  output logic              pclkEn,
  output logic [HW-1:0]     xPos,
  output logic [VW-1:0]     yPos,
  output logic              frameIrq
);
  strobe_t       strb;
  logic          frameEnd;
  logic [PW-1:0] hSyncM1, hBackM1, hFrontM1, vSyncM1, vBackM1, vFrontM1;
  logic [HW-1:0] hActM1;
  logic [VW-1:0] vActM1;
  logic [1:0]    irqSel;
  logic [3:0]    invMask;

  lcd_sync_ctrl #(.PW(PW), .HW(HW), .VW(VW), .DW(DW), .AW(AW), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .frameEnd(frameEnd), .strb(strb),
    .hSyncM1(hSyncM1), .hBackM1(hBackM1), .hFrontM1(hFrontM1),
    .vSyncM1(vSyncM1), .vBackM1(vBackM1), .vFrontM1(vFrontM1),
    .hActM1(hActM1), .vActM1(vActM1), .irqSel(irqSel), .invMask(invMask),
    .pclkOut(pclkOut));

  lcd_sync_dp #(.PW(PW), .HW(HW), .VW(VW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hSyncM1(hSyncM1), .hBackM1(hBackM1), .hFrontM1(hFrontM1),
    .vSyncM1(vSyncM1), .vBackM1(vBackM1), .vFrontM1(vFrontM1),
    .hActM1(hActM1), .vActM1(vActM1), .irqSel(irqSel), .invMask(invMask),
    .frameEnd(frameEnd), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .vdenOut(vdenOut), .pclkEn(pclkEn), .xPos(xPos), .yPos(yPos),
    .frameIrq(frameIrq));

endmodule

// File: tb/sim_lcd_sync_gen.sv
module sim_lcd_sync_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        hsyncOut, vsyncOut, vdenOut, pclkOut, pclkEn, frameIrq;
  logic [10:0] xPos, yPos;

  always #2 clk = ~clk;  // 250 MHz

  lcd_sync_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .vdenOut(vdenOut), .pclkOut(pclkOut), .pclkEn(pclkEn), .xPos(xPos),
    .yPos(yPos), .frameIrq(frameIrq));

  typedef struct {
    bit hs; bit vs; bit de; bit irq;
    int x; int y;
    bit chkGap;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0, errors = 0, popCount = 0, sinceTick = 0;
  bit monEn = 1'b0, done = 1'b0;

  // bench view of the configuration
  int hsN, hbN, haN, hfN, vsN, vbN, vaN, vfN, hT, vT;
  int divB = 0, irqB = 0;
  bit invV = 0, invH = 0, invD = 0, invC = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeCtrl(bit imm, bit frm);
    wr(0, {16'b0, 8'(divB), invC, invD, invH, invV, 2'(irqB), frm, imm});
  endtask

  task automatic setGeom(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf);
    hsN = hs; hbN = hb; haN = ha; hfN = hf; vsN = vs; vbN = vb; vaN = va; vfN = vf;
    hT = hs + hb + ha + hf; vT = vs + vb + va + vf;
    wr(1, {8'b0, 8'(hf - 1), 8'(hb - 1), 8'(hs - 1)});
    wr(2, {8'b0, 8'(vf - 1), 8'(vb - 1), 8'(vs - 1)});
    wr(3, {5'b0, 11'(va - 1), 5'b0, 11'(ha - 1)});
  endtask

  // driver side of the scoreboard: expected pixels from the requirements
  task automatic pushFrames(int n);
    for (int f = 0; f < n; f++)
      for (int v = 0; v < vT; v++)
        for (int h = 0; h < hT; h++) begin
          exp_t e;
          bit hAct, vAct;
          hAct = (h >= hsN + hbN) && (h < hsN + hbN + haN);
          vAct = (v >= vsN + vbN) && (v < vsN + vbN + vaN);
          e.hs = (h < hsN);
          e.vs = (v < vsN);
          e.de = hAct && vAct;
          e.x  = e.de ? h - hsN - hbN : 0;
          e.y  = e.de ? v - vsN - vbN : 0;
          e.irq = (h == 0) && ((irqB == 1 && v == vsN + vbN + vaN) ||
                               (irqB == 2 && v == 0) ||
                               (irqB == 3 && v == vsN + vbN));
          e.chkGap = !(f == 0 && v == 0 && h == 0);
          q.push_back(e);
        end
  endtask

  task automatic checkIdle(string req);
    chk(pclkEn == 1'b0, req, "idle pclkEn", int'(pclkEn), 0);
    chk(frameIrq == 1'b0, req, "idle frameIrq", int'(frameIrq), 0);
    chk(hsyncOut == invH, req, "idle hsync", int'(hsyncOut), int'(invH));
    chk(vsyncOut == invV, req, "idle vsync", int'(vsyncOut), int'(invV));
    chk(vdenOut == invD, req, "idle vden", int'(vdenOut), int'(invD));
    chk(pclkOut == invC, req, "idle pclk", int'(pclkOut), int'(invC));
  endtask

  // run n frames, clearing the frame-synchronised enable during the last one
  task automatic runFrames(int n);
    int base;
    base = popCount;
    pushFrames(n);
    monEn = 1'b1;
    writeCtrl(1, 1);
    while (popCount < base + (n - 1) * hT * vT + 1) @(negedge clk);
    writeCtrl(1, 0);
    while (q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(popCount - base == n * hT * vT, "R8", "pixels delivered", popCount - base, n * hT * vT);
    checkIdle("R8");
    writeCtrl(0, 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN) sinceTick++;
    if (monEn && frameIrq && !pclkEn) chk(1'b0, "R6", "irq without pclkEn", 1, 0);
    if (monEn && pclkEn) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "pixel after expected end", 1, 0);
      end else begin
        cur = q.pop_front();
        chk((hsyncOut ^ invH) == cur.hs, "R1", "hsync", int'(hsyncOut ^ invH), int'(cur.hs));
        chk((vsyncOut ^ invV) == cur.vs, "R2", "vsync", int'(vsyncOut ^ invV), int'(cur.vs));
        chk((vdenOut ^ invD) == cur.de, "R3", "vden", int'(vdenOut ^ invD), int'(cur.de));
        chk(int'(xPos) == cur.x, "R3", "xPos", int'(xPos), cur.x);
        chk(int'(yPos) == cur.y, "R3", "yPos", int'(yPos), cur.y);
        chk(frameIrq == cur.irq, "R6", "frameIrq", int'(frameIrq), int'(cur.irq));
        if (cur.chkGap) chk(sinceTick == divB + 1, "R4", "pixel spacing", sinceTick, divB + 1);
        popCount++;
      end
    end
    if (pclkEn) sinceTick = 0;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state
    checkIdle("R7");

    // config A: divide by 2, three outputs inverted, interrupt at front porch
    divB = 1; irqB = 1; invV = 1; invH = 0; invD = 1; invC = 1;
    setGeom(2, 3, 4, 2, 1, 2, 3, 2);
    writeCtrl(0, 0);
    repeat (2) @(negedge clk);
    checkIdle("R5");
    runFrames(2);

    // config B: divide by 1, no inversion, each interrupt position
    divB = 0; irqB = 2; invV = 0; invH = 0; invD = 0; invC = 0;
    setGeom(1, 1, 3, 1, 2, 1, 2, 1);
    writeCtrl(0, 0);
    runFrames(1);
    irqB = 3; runFrames(1);
    irqB = 0; runFrames(1);

    // R7: enable input dropped mid-frame, then restart from pixel (0,0)
    divB = 2; irqB = 1; invH = 1;
    monEn = 1'b0;
    writeCtrl(1, 1);
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    checkIdle("R7");
    begin
      int base;
      base = popCount;
      pushFrames(1);
      monEn = 1'b1;
      enable = 1'b1;
      writeCtrl(1, 0);
      while (q.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(popCount - base == hT * vT, "R7", "restart frame pixels", popCount - base, hT * vT);
    end
    writeCtrl(0, 0);

    // R7: immediate enable bit cleared mid-frame
    monEn = 1'b0;
    writeCtrl(1, 1);
    repeat (20) @(negedge clk);
    writeCtrl(0, 1);
    @(negedge clk);
    checkIdle("R7");
    writeCtrl(0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule